// File: doc/BRIEF.md
# Fetch-Order Pending Instruction Matcher

This block feeds one generated instruction stream to two consumers during processor co-simulation: the fetch port of a pipelined core and the query port of a reference model. Every core fetch receives a freshly generated pseudo-random 32-bit word, including fetches of an address the core has already fetched. The block also records the pair (fetch address, word) at the tail of a pending queue that stays in fetch order.

The reference model asks for its next instruction by giving its own program counter and the word the core last completed. The block searches the pending queue for an entry on which both values agree. Matching on the address alone is not enough. After a short backward jump the core may prefetch the jump target again, and that creates a newer entry for the same address before the reference model gets there. If the search hits, the oldest agreeing entry is returned, and that entry and every entry older than it are dropped, since they are treated as flushed prefetches. If the search finds nothing, a mismatch is reported.

Both data ports use valid/ready handshakes. The fetch port applies back-pressure only when the queue is full or a seed load is in progress. The query port never applies back-pressure, and its result comes back as a one-cycle pulse with no handshake.

Top module: `instr_stream_matcher`

## Requirements
- R1: After reset the queue is empty, `fetch_ready` is 1, `res_valid`, `res_hit` and `res_miss` are 0, and `fetch_instr` equals the parameter `SEED_INIT`.
- R2: `fetch_instr` always shows the generator state. A fetch is accepted when `fetch_valid` and `fetch_ready` are both high. Each accepted fetch advances the state exactly once by the rule next = (state >> 1) XOR (state[0] ? 32'h80200003 : 0).
- R3: Two accepted fetches of the same address receive different words.
- R4: Each accepted fetch appends (`fetch_pc`, `fetch_instr`) to the queue. `fetch_ready` is 0 whenever the queue holds `DEPTH` entries, so the queue never holds more than `DEPTH` entries.
- R5: `qry_ready` is always 1. An accepted query produces `res_valid` high in the next cycle, with exactly one of `res_hit` and `res_miss` high. Without an accepted query, all three are low in the next cycle.
- R6: A hit requires some queued entry whose address equals `qry_pc` and whose word equals `qry_instr`. On a hit, `res_instr` carries that entry's word.
- R7: A query that matches only the address, or only the word, of every entry gives `res_miss` and leaves the queue unchanged.
- R8: When several entries match, the oldest is chosen. On a hit, the chosen entry and all entries older than it are removed, and all younger entries are kept in order.
- R9: While `seed_load` is high, `fetch_ready` is 0 and the generator is loaded with `seed_value`, or with 1 if `seed_value` is zero.
- R10: When a fetch and a query are accepted in the same cycle, the search covers only entries queued before that cycle. The new entry is appended after any removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load the generator from `seed_value` |
| seed_value | input | 32 | Seed to load (zero is replaced by 1) |
| fetch_valid | input | 1 | Core fetch request |
| fetch_ready | output | 1 | Fetch can be accepted |
| fetch_pc | input | ADDR_W | Core fetch address |
| fetch_instr | output | 32 | Generated word for the current fetch |
| qry_valid | input | 1 | Reference query request |
| qry_ready | output | 1 | Query can be accepted (always 1) |
| qry_pc | input | ADDR_W | Reference program counter |
| qry_instr | input | 32 | Last word completed by the core |
| res_valid | output | 1 | Query result pulse |
| res_hit | output | 1 | Query matched a queued entry |
| res_miss | output | 1 | Query matched no entry |
| res_instr | output | 32 | Matched word, valid with `res_hit` |

## Verification
The assertions check properties that hold on every cycle:
- fetch stalls when the queue is full,
- the occupancy bound,
- result latency and the single-outcome rule,
- the generator holds or advances as required,
- the occupancy effect of a miss and of a hit.

Only the bench's scenarios can show which entry a hit selects and how many entries it drops. The bench shows this by counting how many fetches fit before the queue fills again. It runs a sweep that hits every queue position in turn. It also creates duplicate pairs through seed reloads and aligns a fetch and a query in the same cycle.

// File: rtl/ism_pkg.sv
package ism_pkg;
  typedef logic [31:0] word_t;

  localparam word_t LFSR_MASK = 32'h8020_0003;

  function automatic word_t lfsr_step(input word_t s);
    word_t n;
    n = {1'b0, s[31:1]};
    if (s[0]) n = n ^ LFSR_MASK;
    return n;
  endfunction
endpackage

// File: rtl/ism_lfsr.sv
module ism_lfsr
  import ism_pkg::*;
#(
  parameter word_t SEED_INIT = 32'h1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_val,
  input  logic  advance,
  output word_t state
);
  localparam word_t SAFE_INIT = (SEED_INIT == '0) ? 32'h1 : SEED_INIT;

  word_t state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          state_q <= SAFE_INIT;
    else if (load)       state_q <= (load_val == '0) ? 32'h1 : load_val;
    else if (advance)    state_q <= lfsr_step(state_q);
  end

  assign state = state_q;
endmodule

// File: rtl/ism_pending_q.sv
module ism_pending_q
  import ism_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_pc,
  input  word_t             push_instr,
  input  logic              lookup,
  input  logic [ADDR_W-1:0] look_pc,
  input  word_t             look_instr,
  output logic              found,
  output word_t             found_instr,
  output logic              full,
  output logic [CNT_W-1:0]  occ
);
  logic [ADDR_W-1:0] pc_mem  [DEPTH];
  word_t             ins_mem [DEPTH];
  logic [ADDR_W-1:0] pc_nxt  [DEPTH];
  word_t             ins_nxt [DEPTH];
  logic [CNT_W-1:0]  occ_q, occ_nxt;
  logic [DEPTH-1:0]  match;
  logic [IDX_W-1:0]  sel;
  logic [CNT_W:0]    drop, base;

  // per-slot comparators: slot must be live and agree on both fields
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = (CNT_W'(g) < occ_q) &&
                      (pc_mem[g] == look_pc) && (ins_mem[g] == look_instr);
  end

  // oldest match wins (lowest slot index)
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign found_instr = ins_mem[sel];
  assign full        = (occ_q == CNT_W'(DEPTH));
  assign occ         = occ_q;

  // compaction: drop sel+1 oldest entries on a hit, append new entry after
  always_comb begin
    drop = '0;
    if (lookup && found) drop = {{(CNT_W + 1 - IDX_W){1'b0}}, sel} + (CNT_W + 1)'(1);
    base = {1'b0, occ_q} - drop;
    for (int i = 0; i < DEPTH; i++) begin
      logic [CNT_W:0] src;
      src = (CNT_W + 1)'(i) + drop;
      if (src < (CNT_W + 1)'(DEPTH)) begin
        pc_nxt[i]  = pc_mem[src[IDX_W-1:0]];
        ins_nxt[i] = ins_mem[src[IDX_W-1:0]];
      end else begin
        pc_nxt[i]  = '0;
        ins_nxt[i] = '0;
      end
      if (push && base == (CNT_W + 1)'(i)) begin
        pc_nxt[i]  = push_pc;
        ins_nxt[i] = push_instr;
      end
    end
    occ_nxt = base[CNT_W-1:0] + {{(CNT_W - 1){1'b0}}, push};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        pc_mem[i]  <= '0;
        ins_mem[i] <= '0;
      end
    end else begin
      occ_q <= occ_nxt;
      for (int i = 0; i < DEPTH; i++) begin
        pc_mem[i]  <= pc_nxt[i];
        ins_mem[i] <= ins_nxt[i];
      end
    end
  end
endmodule

// File: rtl/instr_stream_matcher.sv
module instr_stream_matcher
  import ism_pkg::*;
#(
  parameter int    DEPTH     = 8,
  parameter int    ADDR_W    = 32,
  parameter word_t SEED_INIT = 32'h1,
  localparam int   CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [31:0]       seed_value,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [31:0]       fetch_instr,
  input  logic              qry_valid,
  output logic              qry_ready,
  input  logic [ADDR_W-1:0] qry_pc,
  input  logic [31:0]       qry_instr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic [31:0]       res_instr
);
  logic             q_full, q_found, f_acc, q_acc;
  word_t            gen_word, q_word;
  logic [CNT_W-1:0] occ_w;

  assign fetch_ready = !q_full && !seed_load;
  assign qry_ready   = 1'b1;
  assign f_acc       = fetch_valid && fetch_ready;
  assign q_acc       = qry_valid && qry_ready;
  assign fetch_instr = gen_word;

  ism_lfsr #(.SEED_INIT(SEED_INIT)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (seed_load),
    .load_val (seed_value),
    .advance  (f_acc),
    .state    (gen_word)
  );

  ism_pending_q #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_q (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (f_acc),
    .push_pc     (fetch_pc),
    .push_instr  (gen_word),
    .lookup      (q_acc),
    .look_pc     (qry_pc),
    .look_instr  (qry_instr),
    .found       (q_found),
    .found_instr (q_word),
    .full        (q_full),
    .occ         (occ_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_instr <= '0;
    end else begin
      res_valid <= q_acc;
      res_hit   <= q_acc && q_found;
      res_miss  <= q_acc && !q_found;
      if (q_acc && q_found) res_instr <= q_word;
    end
  end
endmodule

// File: rtl/ism_checker.sv
module ism_checker #(
  parameter int  DEPTH  = 8,
  parameter int  ADDR_W = 32,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seed_load,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [31:0]       fetch_instr,
  input logic              qry_valid,
  input logic              qry_ready,
  input logic [31:0]       qry_instr,
  input logic              res_valid,
  input logic              res_hit,
  input logic              res_miss,
  input logic [31:0]       res_instr,
  input logic [CNT_W-1:0]  occ_w
);
  logic fa, qa;
  logic [CNT_W:0] occ_x;
  assign fa    = fetch_valid && fetch_ready;
  assign qa    = qry_valid && qry_ready;
  assign occ_x = {1'b0, occ_w};

  p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_w == CNT_W'(DEPTH)) |-> !fetch_ready);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    occ_w <= CNT_W'(DEPTH));
  p_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fa && !qa) |=> occ_x == $past(occ_x) + 1'b1);
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    qa |=> res_valid);
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !qa |=> (!res_valid && !res_hit && !res_miss));
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_hit, res_miss}));
  p_ready_r5: assert property (@(posedge clk) disable iff (!rst_n) qry_ready);
  p_hit_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    qa |=> (res_hit -> res_instr == $past(qry_instr)));
  p_gen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fa && !seed_load) |=> $stable(fetch_instr));
  p_gen_fresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fa |=> fetch_instr != $past(fetch_instr));
  p_seed_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |-> !fetch_ready);
  p_miss_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (qa && !fa) |=> (res_miss -> occ_x == $past(occ_x)));
  p_hit_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (qa && !fa) |=> (res_hit -> occ_x < $past(occ_x)));
endmodule

bind instr_stream_matcher ism_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .seed_load   (seed_load),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .fetch_instr (fetch_instr),
  .qry_valid   (qry_valid),
  .qry_ready   (qry_ready),
  .qry_instr   (qry_instr),
  .res_valid   (res_valid),
  .res_hit     (res_hit),
  .res_miss    (res_miss),
  .res_instr   (res_instr),
  .occ_w       (occ_w)
);

// File: tb/instr_stream_matcher_tb_top.sv
`timescale 1ns/1ps
module instr_stream_matcher_tb_top;
  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam logic [31:0] SEED0 = 32'h1;

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, seed_load, fetch_valid, fetch_ready, qry_valid, qry_ready;
  logic res_valid, res_hit, res_miss;
  logic [31:0] seed_value, fetch_instr, qry_instr, res_instr;
  logic [AW-1:0] fetch_pc, qry_pc;

  instr_stream_matcher #(.DEPTH(DEPTH), .ADDR_W(AW), .SEED_INIT(SEED0)) dut_i (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_pc(fetch_pc),
    .fetch_instr(fetch_instr), .qry_valid(qry_valid), .qry_ready(qry_ready),
    .qry_pc(qry_pc), .qry_instr(qry_instr), .res_valid(res_valid),
    .res_hit(res_hit), .res_miss(res_miss), .res_instr(res_instr));

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_state;
  logic [AW-1:0] m_pc [DEPTH];
  logic [31:0]   m_in [DEPTH];
  int m_cnt;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_find(input logic [AW-1:0] pc, input logic [31:0] w);
    for (int i = 0; i < m_cnt; i++) if (m_pc[i] == pc && m_in[i] == w) return i;
    return -1;
  endfunction

  task automatic m_drop(input int k);
    for (int i = 0; i < DEPTH; i++) begin
      if (i + k + 1 < m_cnt) begin
        m_pc[i] = m_pc[i + k + 1];
        m_in[i] = m_in[i + k + 1];
      end
    end
    m_cnt -= k + 1;
  endtask

  task automatic m_push(input logic [AW-1:0] pc, input logic [31:0] w);
    m_pc[m_cnt] = pc; m_in[m_cnt] = w; m_cnt++;
  endtask

  // starts and ends at a falling edge
  task automatic fetch_one(input logic [AW-1:0] pc, output bit ok, output logic [31:0] w);
    fetch_valid = 1; fetch_pc = pc;
    #1;
    ok = fetch_ready;
    w  = fetch_instr;
    if (ok) begin
      chk(fetch_instr == m_state, "R2 generated word", fetch_instr, m_state);
      @(posedge clk);
      m_push(pc, m_state);
      m_state = nxt(m_state);
      @(negedge clk);
    end
    fetch_valid = 0;
  endtask

  task automatic query(input logic [AW-1:0] pc, input logic [31:0] w, input string tag, input bit exp_hit);
    int k;
    qry_valid = 1; qry_pc = pc; qry_instr = w;
    @(posedge clk);
    k = m_find(pc, w);
    @(negedge clk);
    qry_valid = 0;
    chk(res_valid == 1'b1, {tag, " res_valid"}, 32'(res_valid), 32'd1);
    chk(res_hit == exp_hit && res_miss == !exp_hit && (k >= 0) == exp_hit,
        {tag, " outcome"}, {30'd0, res_hit, res_miss}, {30'd0, exp_hit, !exp_hit});
    if (exp_hit) begin
      chk(res_instr == w, {tag, " res_instr"}, res_instr, w);
      m_drop(k);
    end
  endtask

  task automatic both(input logic [AW-1:0] fpc, input logic [AW-1:0] qpc,
                      input logic [31:0] qw, input bit exp_hit);
    int k;
    fetch_valid = 1; fetch_pc = fpc;
    qry_valid = 1; qry_pc = qpc; qry_instr = qw;
    @(posedge clk);
    k = m_find(qpc, qw);
    if (k >= 0) m_drop(k);
    m_push(fpc, m_state);
    m_state = nxt(m_state);
    @(negedge clk);
    fetch_valid = 0; qry_valid = 0;
    chk(res_hit == exp_hit && res_miss == !exp_hit && (k >= 0) == exp_hit, "R10 same-cycle outcome",
        {30'd0, res_hit, res_miss}, {30'd0, exp_hit, !exp_hit});
  endtask

  task automatic refill(output int n);
    bit ok; logic [31:0] w;
    n = 0;
    for (int i = 0; i < 2 * DEPTH; i++) begin
      fetch_one(AW'(32'h100 + 4 * i), ok, w);
      if (!ok) break;
      n++;
    end
  endtask

  task automatic load_seed(input logic [31:0] v);
    logic [31:0] e;
    seed_load = 1; seed_value = v;
    #1;
    chk(fetch_ready == 1'b0, "R9 stall during load", 32'(fetch_ready), 32'd0);
    @(posedge clk);
    m_state = (v == 0) ? 32'h1 : v;
    @(negedge clk);
    seed_load = 0;
    e = m_state;
    chk(fetch_instr == e, "R9 seed loaded", fetch_instr, e);
  endtask

  bit done = 0;
  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ok; int n; logic [31:0] w, w4a;
    logic [AW-1:0] pcs [8];
    pcs = '{0, 4, 8, 4, 8, 4, 8, 4};
    rst_n = 0; seed_load = 0; seed_value = 0; fetch_valid = 0; qry_valid = 0;
    fetch_pc = 0; qry_pc = 0; qry_instr = 0;
    m_state = SEED0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(fetch_ready == 1'b1, "R1 fetch_ready", 32'(fetch_ready), 32'd1);
    chk(!res_valid && !res_hit && !res_miss, "R1 result idle", {29'd0, res_valid, res_hit, res_miss}, 32'd0);
    chk(fetch_instr == SEED0, "R1 seed", fetch_instr, SEED0);
    chk(qry_ready == 1'b1, "R5 qry_ready", 32'(qry_ready), 32'd1);
    @(negedge clk);

    // loop-like fetch pattern with repeated addresses
    w4a = '0;
    for (int i = 0; i < DEPTH; i++) begin
      fetch_one(pcs[i], ok, w);
      if (i == 1) w4a = w;
      if (i == 3) chk(w != w4a, "R3 repeated pc fresh word", w, ~w4a);
    end
    fetch_one(32'h20, ok, w);
    chk(!ok, "R4 full stalls fetch", 32'(ok), 32'd0);

    // partial matches
    query(32'h4, m_in[2], "R7 pc-only", 1'b0);
    query(32'hC, m_in[0], "R7 word-only", 1'b0);
    refill(n);
    chk(n == 0, "R7 queue unchanged", 32'(n), 32'd0);

    // sweep every position: hit removes it and all older
    for (int k = 0; k < DEPTH; k++) begin
      query(m_pc[k], m_in[k], "R6 R8 sweep hit", 1'b1);
      refill(n);
      chk(n == k + 1, "R8 entries removed", 32'(n), 32'(k + 1));
    end

    // empty the queue, then build duplicate pairs via seed reload
    query(m_pc[DEPTH - 1], m_in[DEPTH - 1], "R8 drain", 1'b1);
    load_seed(32'h1234_5678);
    fetch_one(32'h4, ok, w);
    load_seed(32'h1234_5678);
    fetch_one(32'h4, ok, w);
    fetch_one(32'h8, ok, w);
    query(32'h4, 32'h1234_5678, "R8 duplicate hit", 1'b1);
    refill(n);
    chk(n == DEPTH - 2, "R8 oldest duplicate only", 32'(n), 32'(DEPTH - 2));
    load_seed(32'h0);

    // same-cycle fetch and query
    query(m_pc[0], m_in[0], "R10 make room", 1'b1);
    both(32'h40, m_pc[0], m_in[0], 1'b1);
    refill(n);
    chk(n == 1, "R10 push after removal", 32'(n), 32'd1);
    query(m_pc[0], m_in[0], "R10 make room", 1'b1);
    #1;
    w = fetch_instr;
    both(32'h44, 32'h44, w, 1'b0);
    refill(n);
    chk(n == 0, "R10 new entry not searched", 32'(n), 32'd0);
    query(32'h44, w, "R10 new entry visible later", 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule